// File: doc/BRIEF.md
# Data-Run Frequency Lock Detector

This block decides when a clock recovery loop has stopped needing frequency correction. It watches the incoming serial data and the two correction requests issued by the frequency detector (raise and lower). Every rising data transition goes into a divide-by-two stage. Each rising edge of the divided stream moves a run counter forward by one. Any correction request empties the counter. When the run reaches the terminal count of the counter, a sticky lock flag goes high. Lock is therefore reported only after a long stretch of data with no frequency correction at all.

The block works in a single system clock domain. The serial data input is synchronised and then edge-detected, so the divider and counter act on detected transitions rather than being clocked by the data itself. The correction requests are synchronous to the system clock and take effect in the cycle they are sampled. An enable input returns the divider, the counter and the flag to their idle state, and the detector runs only while it is high.

Top module: `flock_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released, `lock` is 0.
- R2: From a cleared state, with the divider phase at 0, the run counter advances on the 1st, 3rd, 5th, ... rising edges of `din`: the divided stream toggles on every rising data edge, and only its 0-to-1 transitions count.
- R3: `lock` goes high once the counter reaches its terminal value 2^CNT_W-1. With the default CNT_W=8 this is 255, so 509 rising data edges are needed from a cleared state with the divider at 0. `lock` is not high after only 508.
- R4: A high `up` or `dn` in any sampled cycle clears the counter to 0. This overrides a count step that falls in the same cycle. The divider phase is not affected by `up` or `dn`.
- R5: At the terminal value the counter saturates. Further data edges neither wrap it nor drop `lock`.
- R6: Once `lock` is high it stays high through further `up`/`dn` pulses and data edges, for as long as `en` stays high.
- R7: A low `en` clears the divider, the counter and `lock`. While `en` is low, data edges do not count.
- R8: A single `up` pulse one data edge before threshold delays `lock` by a full threshold count. After it, 508 further edges leave `lock` low and the 509th sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detector enable; low clears all state |
| din | input | 1 | Serial data, asynchronous to clk |
| up | input | 1 | Frequency-raise request from the frequency detector |
| dn | input | 1 | Frequency-lower request from the frequency detector |
| lock | output | 1 | Sticky frequency-lock flag |

## Verification
A count step (a detected 0-to-1 transition of the divided data) and a correction request can land in the same clock cycle. The clear must win, and the divider must still toggle. The bench provokes this by holding `up` or `dn` high exactly in the cycle after the synchronised data edge is seen, both in directed cases and at random points in long runs. It judges the result by whether `lock` appears only after the full number of further edges predicted by its own edge-level model, which carries the divider phase across the collision.

// File: rtl/flock_pkg.sv
package flock_pkg;

  // Control word handed from the top to the run counter.
  typedef struct packed {
    logic clear;
    logic step;
  } flock_ctl_t;

  // Terminal value of a counter of the given width.
  function automatic int unsigned terminal_of(int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // Rising data edges needed from a cleared state with divider phase 0.
  function automatic int unsigned edges_to_lock(int unsigned w);
    return 2 * terminal_of(w) - 1;
  endfunction

endpackage

// File: rtl/flock_edge_div.sv
module flock_edge_div #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic div_rise
);

  logic din_s;
  logic din_d;
  logic div_q;
  logic din_rise;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_s <= 1'b0;
        else        din_s <= din;
      end
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], din};
      end
      assign din_s = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_d <= 1'b0;
    else        din_d <= din_s;
  end

  assign din_rise = din_s & ~din_d;

  // Divide-by-two of the data: toggles once per rising data edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= 1'b0;
    else if (!en)      div_q <= 1'b0;
    else if (din_rise) div_q <= ~div_q;
  end

  // Rising edge of the divided stream.
  assign div_rise = en & din_rise & ~div_q;

endmodule

// File: rtl/flock_run_counter.sv
module flock_run_counter
  import flock_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  flock_ctl_t       ctl,
  output logic [CNT_W-1:0] cnt,
  output logic             at_term
);

  localparam logic [CNT_W-1:0] TERM = '1;

  function automatic logic [CNT_W-1:0] sat_next(logic [CNT_W-1:0] c, logic stp);
    if (stp && c != TERM) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || ctl.clear) cnt <= '0;
    else                       cnt <= sat_next(cnt, ctl.step);
  end

  assign at_term = (cnt == TERM);

endmodule

// File: rtl/flock_lock_hold.sv
module flock_lock_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  output logic lock
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lock <= 1'b0;
    else if (!en) lock <= 1'b0;
    else if (set) lock <= 1'b1;
  end

endmodule

// File: rtl/flock_detect.sv
module flock_detect
  import flock_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  input  logic up,
  input  logic dn,
  output logic lock
);

  localparam int unsigned TERM_VAL = terminal_of(CNT_W);

  logic             div_rise;
  logic [CNT_W-1:0] run_cnt;
  logic             at_term;
  flock_ctl_t       ctl;

  assign ctl.clear = up | dn;
  assign ctl.step  = div_rise;

  flock_edge_div #(.SYNC_STAGES(SYNC_STAGES)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .din      (din),
    .div_rise (div_rise)
  );

  flock_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ctl     (ctl),
    .cnt     (run_cnt),
    .at_term (at_term)
  );

  flock_lock_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .set   (at_term),
    .lock  (lock)
  );

  initial begin
    if (TERM_VAL == 0) $display("flock_detect: zero terminal value");
  end

endmodule

// File: rtl/flock_detect_chk.sv
module flock_detect_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             up,
  input logic             dn,
  input logic             lock,
  input logic [CNT_W-1:0] cnt,
  input logic             div_rise,
  input logic             at_term
);

  localparam logic [CNT_W-1:0] TERM = '1;

  // R4: any correction request empties the counter next cycle
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (up || dn) |=> (cnt == '0));

  // R2: the counter moves only on a divided-data rising edge
  a_r2_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && !dn && !div_rise) |=> $stable(cnt));

  // R2: a step below terminal adds exactly one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && !dn && div_rise && cnt != TERM) |=> (cnt == $past(cnt) + 1'b1));

  // R5: saturation at terminal
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && !dn && cnt == TERM) |=> (cnt == TERM));

  // R3: terminal value raises the flag
  a_r3_lock_at_term: assert property (@(posedge clk) disable iff (!rst_n)
    (en && at_term) |=> lock);

  // R6: sticky flag while enabled
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lock) |=> lock);

  // R7: disable clears counter and flag
  a_r7_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lock && cnt == '0));

  // R3: flag never rises without the counter having reached terminal
  a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(at_term));

endmodule

bind flock_detect flock_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .up       (up),
  .dn       (dn),
  .lock     (lock),
  .cnt      (run_cnt),
  .div_rise (div_rise),
  .at_term  (at_term)
);

// File: tb/flock_detect_bench.sv
`timescale 1ns/1ps
module flock_detect_bench;

  localparam int CNT_W = 8;
  localparam int LIMIT = (1 << CNT_W) - 1;   // counter terminal
  localparam int NEED  = 2 * LIMIT - 1;      // edges to lock from clean state

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  logic up = 1'b0;
  logic dn = 1'b0;
  logic lock;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model, kept at data-edge granularity
  int m_cnt = 0;
  bit m_div = 1'b0;
  bit m_lock = 1'b0;

  always #2.5 clk = ~clk;

  flock_detect #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_flock_detect (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .up(up), .dn(dn), .lock(lock)
  );

  function automatic int model_count(int c, bit div_phase, bit clr);
    if (clr) return 0;
    if (!div_phase && c < LIMIT) return c + 1;
    return c;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: lock=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_div = 1'b0; m_lock = 1'b0;
  endtask

  // One rising data edge; optional correction pulse in the step cycle.
  task automatic data_edge(bit pu, bit pd);
    din = 1'b1;
    @(negedge clk);
    @(negedge clk);
    up = pu; dn = pd; din = 1'b0;
    @(negedge clk);
    up = 1'b0; dn = 1'b0;
    @(negedge clk);
    if (en) begin
      m_cnt = model_count(m_cnt, m_div, pu | pd);
      m_div = ~m_div;
      if (m_cnt == LIMIT) m_lock = 1'b1;
    end
  endtask

  // Correction pulse away from any data edge.
  task automatic idle_pulse(bit pu, bit pd);
    up = pu; dn = pd;
    @(negedge clk);
    up = 1'b0; dn = 1'b0;
    @(negedge clk);
    if (en && (pu | pd)) m_cnt = 0;
  endtask

  task automatic run_edges(int n, string tag);
    for (int i = 0; i < n; i++) data_edge(1'b0, 1'b0);
    check(tag, lock, m_lock);
  endtask

  task automatic disable_pulse();
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    model_clear();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", lock, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", lock, 1'b0);
    en = 1'b1;
    @(negedge clk);
    model_clear();

    // R2/R3: exact threshold
    run_edges(NEED - 1, "R3 one edge short");
    check("R2 model short", lock, 1'b0);
    run_edges(1, "R3 threshold edge");
    check("R3 lock set", lock, 1'b1);

    // R5/R6: further edges and corrections keep lock
    run_edges(40, "R5 saturate extra edges");
    idle_pulse(1'b1, 1'b0);
    idle_pulse(1'b0, 1'b1);
    data_edge(1'b1, 1'b1);
    check("R6 sticky after corrections", lock, 1'b1);

    // R7: disable clears, edges ignored while low
    en = 1'b0;
    @(negedge clk);
    check("R7 disable clears lock", lock, 1'b0);
    for (int i = 0; i < NEED + 4; i++) data_edge(1'b0, 1'b0);
    check("R7 edges ignored while low", lock, 1'b0);
    en = 1'b1;
    @(negedge clk);
    model_clear();

    // R8: single up one edge before threshold
    run_edges(NEED - 1, "R8 pre-threshold");
    idle_pulse(1'b1, 1'b0);
    run_edges(NEED - 1, "R8 still low after restart");
    check("R8 no lock yet", lock, 1'b0);
    run_edges(1, "R8 full restart count");
    check("R8 lock after full count", lock, 1'b1);

    // R4: coincident clear on a counting edge (divider phase kept)
    disable_pulse();
    run_edges(NEED - 3, "R4 setup");
    data_edge(1'b0, 1'b1);   // coincides with a count step
    check("R4 coincident dn cleared", lock, m_lock);
    run_edges(NEED - 1, "R4 after coincident dn");
    check("R4 no lock before full run", lock, 1'b0);
    run_edges(2, "R4 lock after full run");
    check("R4 lock matches model", lock, m_lock);

    // R2: clear on the non-counting phase
    disable_pulse();
    data_edge(1'b0, 1'b0);
    data_edge(1'b1, 1'b0);   // divider at 1: no step, clear only
    run_edges(NEED - 1, "R2 phase kept short");
    run_edges(1, "R2 phase kept lock");

    // Random mix, checked per edge against the model
    begin
      int unsigned seed_v;
      seed_v = $urandom(32'h5eed_1234);
      disable_pulse();
      for (int i = 0; i < 9000; i++) begin
        int unsigned r;
        r = $urandom_range(0, 999);
        if (r < 2) begin
          disable_pulse();
        end else if (r < 4) begin
          idle_pulse(r[0], ~r[0]);
        end else if (r < 6) begin
          data_edge(r[0], ~r[0]);
          check("R4 random coincident", lock, m_lock);
        end else begin
          data_edge(1'b0, 1'b0);
          checks++;
          if (lock !== m_lock) begin
            failures++;
            $display("FAIL R3/R6 random edge %0d: lock=%0b expected=%0b", i, lock, m_lock);
          end
        end
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule